// File: doc/BRIEF.md
# Bus-Shared 8-bit Accumulator Processor

This block is a small 8-bit processor in which every storage element talks over one shared data bus. A 16-word memory, a 4-bit program counter, an accumulator, a second operand register, an instruction register, a memory address register, an adder/subtractor with zero and carry flags, and an output register all take their data from that bus. In each clock cycle at most one of them places a value on it. A microcode sequencer sets the control lines for every cycle. It looks up the current opcode, the microstep within the instruction, and the two flags.

A program image is written into memory through a load port while the machine is held in reset. After reset is released, the processor either runs freely, taking one microstep per clock, or, in manual mode, takes one microstep for each cycle in which a step request is high. The output register is presented at the ports with a registered flag that selects signed or unsigned display of its value. Driving the display itself is left to the surrounding logic.

Top module: `busacc_cpu`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_value` is 0, `halted` is 0 and `out_signed` is 0.
- R2: In every cycle at most one source drives the shared bus. The sources are the program counter, the memory, the instruction operand, the accumulator and the adder.
- R3: Every instruction takes exactly five microsteps. Microsteps 0 and 1 fetch the instruction and increment the program counter. In free-run mode, instruction i (counting from 0) performs microstep s at clock edge 5i+s+1 after reset is released. A HLT that comes after k instructions therefore raises `halted` at edge 5k+3.
- R4: An instruction word holds the opcode in bits 7:4 and an address or immediate in bits 3:0. The opcodes are NOP=0, LDA=1, ADD=2, SUB=3, STA=4, LDI=5, JMP=6, JC=7, JZ=8, OUT=14 and HLT=15. OUT copies the accumulator into `out_value` at microstep 2. `out_value` changes at no other time.
- R5: ADD sets the accumulator to (A + mem[addr]) mod 256. The carry flag receives bit 8 of the true sum.
- R6: SUB sets the accumulator to (A − mem[addr]) mod 256, computed as A + ~B + 1. The carry flag is 1 exactly when A ≥ B as unsigned values.
- R7: Z (result equals 0) and C are written only by ADD and SUB. All other instructions leave them unchanged. JC and JZ load the program counter from the operand when their flag is 1, and otherwise fall through.
- R8: LDA loads the accumulator from memory, LDI loads the zero-extended operand, STA writes the accumulator to memory, and JMP jumps unconditionally. The program counter wraps from 15 to 0.
- R9: When `run_mode` is 0, the processor state and the outputs advance only in cycles in which `step_req` is 1. Each such cycle performs one microstep.
- R10: After HLT, `halted` stays 1 and `out_value` holds its value until reset.
- R11: `out_signed` equals the value `disp_signed` had on the previous clock edge.
- R12: A cycle with `load_en` high writes `load_data` to memory word `load_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_mode | input | 1 | 1: one microstep per clock; 0: manual stepping |
| step_req | input | 1 | In manual mode, perform one microstep this cycle |
| disp_signed | input | 1 | Display mode request, 1 selects two's-complement |
| load_en | input | 1 | Program-load write enable |
| load_addr | input | 4 | Program-load word address |
| load_data | input | 8 | Program-load word |
| out_value | output | 8 | Output register |
| out_signed | output | 1 | Registered display mode for `out_value` |
| halted | output | 1 | Processor has executed HLT |

## Verification
The assertions assume the following about the inputs:
- `load_en` is raised only while reset is held, because a load takes over the memory write port from a running program.
- Every stored program reaches HLT.
- Inputs change away from the rising clock edge.

The bench keeps to these assumptions in the following way:
- It writes all sixteen words of each image during reset.
- It builds every image so that each branch path ends in HLT.
- It drives all inputs on the falling edge, with `step_req` as single-cycle pulses.

The bench sweeps ADD and SUB over an 8×8 grid of operand values that includes 0, 1, 0x7F, 0x80 and 0xFF. For each pair it checks the result, both flags (through branches), and the exact halt cycle of each path.

// File: rtl/busacc_pkg.sv
package busacc_pkg;

  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int USTEPS  = 5;

  // Opcode values (upper nibble of the instruction word)
  typedef enum logic [3:0] {
    OP_NOP = 4'h0,
    OP_LDA = 4'h1,
    OP_ADD = 4'h2,
    OP_SUB = 4'h3,
    OP_STA = 4'h4,
    OP_LDI = 4'h5,
    OP_JMP = 4'h6,
    OP_JC  = 4'h7,
    OP_JZ  = 4'h8,
    OP_OUT = 4'hE,
    OP_HLT = 4'hF
  } opcode_e;

  // One microstep's worth of control lines
  typedef struct packed {
    logic hlt;
    logic mar_ld;
    logic ram_wr;
    logic ram_oe;
    logic ir_oe;
    logic ir_ld;
    logic a_ld;
    logic a_oe;
    logic alu_oe;
    logic alu_sub;
    logic b_ld;
    logic out_ld;
    logic pc_inc;
    logic pc_oe;
    logic pc_ld;
    logic flg_ld;
  } uctl_t;

endpackage

// File: rtl/busacc_ram.sv
module busacc_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Combinational read so memory can drive the bus in the same microstep
  assign rdata = mem[raddr];
endmodule

// File: rtl/busacc_alu.sv
module busacc_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          zero
);
  logic [DW:0]   wide;
  logic [DW-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, sub};
  end

  assign res  = wide[DW-1:0];
  assign cout = wide[DW];
  assign zero = (wide[DW-1:0] == '0);
endmodule

// File: rtl/busacc_seq.sv
module busacc_seq
  import busacc_pkg::*;
#(
  parameter int OPW   = 4,
  parameter int STEPS = 5,
  localparam int SW   = $clog2(STEPS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv,
  input  logic [OPW-1:0] op,
  input  logic           zf,
  input  logic           cf,
  output logic [SW-1:0]  step,
  output uctl_t          uc,
  output logic           halted
);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  uctl_t u;

  always_comb begin
    u = '0;
    case (step)
      SW'(0): begin u.pc_oe = 1'b1; u.mar_ld = 1'b1; end
      SW'(1): begin u.ram_oe = 1'b1; u.ir_ld = 1'b1; u.pc_inc = 1'b1; end
      SW'(2): begin
        case (op)
          OP_LDA, OP_ADD, OP_SUB, OP_STA: begin u.ir_oe = 1'b1; u.mar_ld = 1'b1; end
          OP_LDI: begin u.ir_oe = 1'b1; u.a_ld = 1'b1; end
          OP_JMP: begin u.ir_oe = 1'b1; u.pc_ld = 1'b1; end
          OP_JC:  begin u.ir_oe = cf; u.pc_ld = cf; end
          OP_JZ:  begin u.ir_oe = zf; u.pc_ld = zf; end
          OP_OUT: begin u.a_oe = 1'b1; u.out_ld = 1'b1; end
          OP_HLT: u.hlt = 1'b1;
          default: ;
        endcase
      end
      SW'(3): begin
        case (op)
          OP_LDA: begin u.ram_oe = 1'b1; u.a_ld = 1'b1; end
          OP_ADD, OP_SUB: begin u.ram_oe = 1'b1; u.b_ld = 1'b1; end
          OP_STA: begin u.a_oe = 1'b1; u.ram_wr = 1'b1; end
          default: ;
        endcase
      end
      SW'(4): begin
        if (op == OP_ADD || op == OP_SUB) begin
          u.alu_oe  = 1'b1;
          u.alu_sub = (op == OP_SUB);
          u.a_ld    = 1'b1;
          u.flg_ld  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // Control lines are active only in cycles that actually advance
  assign uc = (adv && !halted) ? u : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= '0;
      halted <= 1'b0;
    end else begin
      if (adv && !halted) step <= (step == LAST) ? '0 : step + SW'(1);
      if (uc.hlt) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/busacc_cpu.sv
module busacc_cpu
  import busacc_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int STEPS = USTEPS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_mode,
  input  logic          step_req,
  input  logic          disp_signed,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  output logic [DW-1:0] out_value,
  output logic          out_signed,
  output logic          halted
);
  localparam int OPW  = DW - AW;
  localparam int SW   = $clog2(STEPS);
  localparam int NSRC = 5;
  localparam int S_PC = 0, S_RAM = 1, S_IR = 2, S_A = 3, S_ALU = 4;

  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] a_q, b_q, ir_q;
  logic          zf_q, cf_q;
  logic [DW-1:0] bus;
  logic [SW-1:0] step;
  uctl_t         uc;
  logic          adv;

  logic [DW-1:0] ram_rd, alu_res;
  logic          alu_c, alu_z;

  logic [NSRC-1:0] drv;
  logic [DW-1:0]   src [NSRC];

  assign adv = run_mode | step_req;

  busacc_seq #(.OPW(OPW), .STEPS(STEPS)) u_seq (
    .clk(clk), .rst(rst), .adv(adv), .op(ir_q[DW-1:AW]),
    .zf(zf_q), .cf(cf_q), .step(step), .uc(uc), .halted(halted)
  );

  busacc_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk),
    .we(load_en | uc.ram_wr),
    .waddr(load_en ? load_addr : mar_q),
    .wdata(load_en ? load_data : bus),
    .raddr(mar_q),
    .rdata(ram_rd)
  );

  busacc_alu #(.DW(DW)) u_alu (
    .a(a_q), .b(b_q), .sub(uc.alu_sub),
    .res(alu_res), .cout(alu_c), .zero(alu_z)
  );

  // Bus: one-hot gated OR of all sources (tri-state replacement)
  assign drv[S_PC]  = uc.pc_oe;
  assign drv[S_RAM] = uc.ram_oe;
  assign drv[S_IR]  = uc.ir_oe;
  assign drv[S_A]   = uc.a_oe;
  assign drv[S_ALU] = uc.alu_oe;

  assign src[S_PC]  = {{(DW-AW){1'b0}}, pc_q};
  assign src[S_RAM] = ram_rd;
  assign src[S_IR]  = {{(DW-AW){1'b0}}, ir_q[AW-1:0]};
  assign src[S_A]   = a_q;
  assign src[S_ALU] = alu_res;

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (drv[i]) bus = bus | src[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= '0;
      mar_q      <= '0;
      a_q        <= '0;
      b_q        <= '0;
      ir_q       <= '0;
      zf_q       <= 1'b0;
      cf_q       <= 1'b0;
      out_value  <= '0;
      out_signed <= 1'b0;
    end else begin
      out_signed <= disp_signed;
      if (uc.mar_ld) mar_q <= bus[AW-1:0];
      if (uc.ir_ld)  ir_q  <= bus;
      if (uc.a_ld)   a_q   <= bus;
      if (uc.b_ld)   b_q   <= bus;
      if (uc.out_ld) out_value <= bus;
      if (uc.pc_ld)       pc_q <= bus[AW-1:0];
      else if (uc.pc_inc) pc_q <= pc_q + AW'(1);
      if (uc.flg_ld) begin
        zf_q <= alu_z;
        cf_q <= alu_c;
      end
    end
  end
endmodule

// File: rtl/busacc_chk.sv
module busacc_chk #(
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter int STEPS = 5,
  localparam int SW   = $clog2(STEPS)
) (
  input logic          clk,
  input logic          rst,
  input logic          run_mode,
  input logic          step_req,
  input logic [SW-1:0] step,
  input logic [AW-1:0] pc,
  input logic [4:0]    drv,
  input logic          out_ld,
  input logic [DW-1:0] out_value,
  input logic          halted
);
  logic adv;
  assign adv = run_mode | step_req;

  AST_BUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv));  // R2

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
    step <= SW'(STEPS - 1));  // R3

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && !halted && step == SW'(STEPS - 1)) |=> step == '0);  // R3

  AST_OUT_ONLY_ON_OUT: assert property (@(posedge clk) disable iff (rst)
    !out_ld |=> $stable(out_value));  // R4

  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run_mode && !step_req) |=> ($stable(step) && $stable(pc)));  // R9

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(out_value) && $stable(pc)));  // R10
endmodule

bind busacc_cpu busacc_chk #(.DW(DW), .AW(AW), .STEPS(STEPS)) u_chk (
  .clk(clk), .rst(rst), .run_mode(run_mode), .step_req(step_req),
  .step(step), .pc(pc_q), .drv(drv), .out_ld(uc.out_ld),
  .out_value(out_value), .halted(halted)
);

// File: tb/busacc_cpu_tb.sv
module busacc_cpu_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_mode = 1'b1;
  logic       step_req = 1'b0;
  logic       disp_signed = 1'b0;
  logic       load_en = 1'b0;
  logic [3:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic [7:0] out_value;
  logic       out_signed;
  logic       halted;

  int checks = 0;
  int errors = 0;
  logic [7:0] img [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  busacc_cpu u_dut (
    .clk(clk), .rst(rst), .run_mode(run_mode), .step_req(step_req),
    .disp_signed(disp_signed), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .out_value(out_value), .out_signed(out_signed),
    .halted(halted)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 16; i++) img[i] = 8'h00;
  endtask

  // Hold reset and write the whole image through the load port (R12)
  task automatic load_img();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      load_en = 1'b1; load_addr = 4'(i); load_data = img[i];
      @(negedge clk);
    end
    load_en = 1'b0;
    @(negedge clk);
  endtask

  // Release reset in free-run mode; count edges until halted
  task automatic run_free(output int cyc, output logic [7:0] o13);
    run_mode = 1'b1;
    rst = 1'b0;
    cyc = 0; o13 = 8'h00;
    while (!halted && cyc < 400) begin
      @(posedge clk); #1;
      cyc++;
      if (cyc == 13) o13 = out_value;
    end
    if (!halted) chk("R10 watchdog on program", 0, 1);
  endtask

  task automatic pulse_step();
    @(negedge clk) step_req = 1'b1;
    @(negedge clk) step_req = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    chk("watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int cyc;
    logic [7:0] o13;
    logic [7:0] vals [8];
    vals = '{8'h00, 8'h01, 8'h02, 8'h55, 8'h7F, 8'h80, 8'hAA, 8'hFF};

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_value in reset", int'(out_value), 0);
    chk("R1 halted in reset", int'(halted), 0);
    chk("R1 out_signed in reset", int'(out_signed), 0);

    // ADD/SUB sweep: R4 R5 R6 R7 R3
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          int x, y, sum, res, c, z, kexp;
          x = int'(vals[i]); y = int'(vals[j]);
          clear_img();
          img[0]  = 8'h1E;                    // LDA 14
          img[1]  = (s == 0) ? 8'h2F : 8'h3F; // ADD/SUB 15
          img[2]  = 8'hE0;                    // OUT
          img[3]  = 8'h76;                    // JC 6
          img[4]  = 8'h50;                    // LDI 0
          img[5]  = 8'h67;                    // JMP 7
          img[6]  = 8'h51;                    // LDI 1
          img[7]  = 8'h8A;                    // JZ 10
          img[8]  = 8'hE0;                    // OUT
          img[9]  = 8'hF0;                    // HLT
          img[10] = 8'h2D;                    // ADD 13
          img[11] = 8'hE0;                    // OUT
          img[12] = 8'hF0;                    // HLT
          img[13] = 8'h02;
          img[14] = vals[i];
          img[15] = vals[j];
          load_img();
          if (s == 0) begin
            sum = x + y;
            c = (sum > 255) ? 1 : 0;
          end else begin
            sum = x - y;
            c = (x >= y) ? 1 : 0;
          end
          res = sum & 8'hFF;
          z = (res == 0) ? 1 : 0;
          kexp = 4 + (c != 0 ? 1 : 2) + 1 + (z != 0 ? 2 : 1);
          run_free(cyc, o13);
          if (s == 0) chk("R5 ADD result", int'(o13), res);
          else        chk("R6 SUB result", int'(o13), res);
          chk("R7 flags via JC/JZ", int'(out_value), c + 2 * z);
          chk("R3 halt edge", cyc, 5 * kexp + 3);
        end
      end
    end

    // R8: LDI, STA, LDA, ADD from stored word
    clear_img();
    img[0] = 8'h57; img[1] = 8'h4F; img[2] = 8'h1F;
    img[3] = 8'h2F; img[4] = 8'hE0; img[5] = 8'hF0;
    load_img();
    run_free(cyc, o13);
    chk("R8 STA then LDA/ADD", int'(out_value), 14);
    chk("R3 halt edge STA prog", cyc, 5 * 5 + 3);
    // R10: frozen after halt
    repeat (30) @(negedge clk);
    chk("R10 halted stays", int'(halted), 1);
    chk("R10 out_value holds", int'(out_value), 14);
    // R1: reset clears again
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    chk("R1 out_value after reset", int'(out_value), 0);
    chk("R1 halted after reset", int'(halted), 0);

    // R8: PC wrap 15 -> 0, R7: Z kept across LDI/JMP/NOP
    clear_img();
    img[0] = 8'h84; img[1] = 8'h3D; img[2] = 8'h55; img[3] = 8'h6F;
    img[4] = 8'hE0; img[5] = 8'hF0; img[13] = 8'h00; img[15] = 8'h00;
    load_img();
    run_free(cyc, o13);
    chk("R8 PC wrap result", int'(out_value), 5);
    chk("R7 JZ after LDI/JMP halt edge", cyc, 5 * 7 + 3);

    // R9: manual stepping
    clear_img();
    img[0] = 8'h59; img[1] = 8'hE0; img[2] = 8'hF0;
    load_img();
    run_mode = 1'b0;
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 idle without step out", int'(out_value), 0);
    chk("R9 idle without step halted", int'(halted), 0);
    for (int n = 1; n <= 13; n++) begin
      pulse_step();
      if (n == 7)  chk("R9 before OUT step", int'(out_value), 0);
      if (n == 8)  chk("R9 OUT at step 8", int'(out_value), 9);
      if (n == 12) chk("R9 not halted at 12", int'(halted), 0);
      if (n == 13) chk("R9 halted at 13", int'(halted), 1);
    end

    // R11: display mode register
    @(negedge clk) disp_signed = 1'b1;
    chk("R11 before edge", int'(out_signed), 0);
    @(negedge clk);
    chk("R11 after edge", int'(out_signed), 1);
    disp_signed = 1'b0;
    @(negedge clk);
    chk("R11 back to unsigned", int'(out_signed), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule